// File: doc/BRIEF.md
# Timer Channel Count Load and Readback Sequencer

This block is the host-facing byte path of one timer channel. The host writes a 16-bit preset as one or two bytes, and the block assembles it. A byte-format code, programmed by a mode-set pulse, picks how the preset is assembled: low byte only, high byte only, or low byte followed by high byte. When the preset is complete, the block presents it together with a one-cycle "new count ready" strobe. The down-counter consumes that strobe in the channel clock domain, where the new value takes effect after the next rising and then falling channel-clock edge. While the block waits for the second byte of a two-byte load it raises a "loading" flag, so that a one-shot counter can hold still until the load completes.

On the read side, the block serves the counter value back to the host one byte per read strobe, using the same byte format. A latch pulse freezes a snapshot of the live count. Later reads return the snapshot while the counter keeps running, and the snapshot is released once the programmed number of bytes has been read. The block also gives the effective length of the preset. A preset of zero stands for the full range, and in BCD mode the four decimal digits are converted to their numeric value.

Top module: `tmr_count_seq`

## Requirements
- R1: After reset, `preset` is 0, `load_go` and `loading` are low, the format is low-then-high, the read pointer is on the low byte, and no snapshot is held.
- R2: With format code 2'b01, each write sets `preset` to {8'h00, byte} and pulses `load_go` on the same clock edge.
- R3: With format code 2'b10, each write sets `preset` to {byte, 8'h00} and pulses `load_go` on the same clock edge.
- R4: With format code 2'b11, the first write raises `loading` and leaves `preset` and `load_go` unchanged. The second write sets `preset` to {second, first}, drops `loading` and pulses `load_go`.
- R5: `load_go` is high for one cycle per completed load, and only after a write strobe.
- R6: With format code 2'b01, a read returns bits [7:0] of the source value. With format code 2'b10, it returns bits [15:8].
- R7: With format code 2'b11, successive reads return the low byte and then the high byte, after which the pointer goes back to the low byte.
- R8: A latch pulse captures `count_val`. Reads return the captured value until the last byte of the read sequence, and then go back to the live `count_val`.
- R9: A latch pulse that arrives while a snapshot is still held is ignored.
- R10: A mode-set pulse with a nonzero format code stores the format, returns both the write and the read pointers to the first byte, drops `loading` and releases any snapshot.
- R11: A mode-set pulse with format code 2'b00 is ignored.
- R12: `preset_span` gives the preset length. In binary mode it is the preset value. In BCD mode it is the decimal value of the four digits. A zero preset gives 65536 in binary mode and 10000 in BCD mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_set | input | 1 | Mode-set pulse, samples `mode_fmt` |
| mode_fmt | input | 2 | Byte format: 01 low, 10 high, 11 low then high |
| bcd_mode | input | 1 | Channel counts in BCD |
| wr_stb | input | 1 | Count byte write pulse |
| wr_data | input | 8 | Count byte being written |
| rd_stb | input | 1 | Count byte read pulse |
| latch_stb | input | 1 | Snapshot request |
| count_val | input | 16 | Live counter value |
| preset | output | 16 | Assembled preset |
| preset_span | output | 17 | Effective preset length |
| load_go | output | 1 | New count ready, one cycle |
| loading | output | 1 | Two-byte load half done |
| rd_data | output | 8 | Byte returned to the host for the current read |

## Verification
On every cycle, the assertions check that the load strobe follows a write, that the preset changes only together with that strobe, that `loading` falls only on a completed load or on a mode set, and that a binary span matches the preset and is never zero. Only the bench scenarios show how the bytes are ordered, how the snapshot holds and is released, that a second latch is ignored, that a mode set with format 00 is ignored, and how BCD digits are converted. These depend on sequences of host operations whose results can only be seen at later reads.

// File: rtl/tmr_seq_pkg.sv
package tmr_seq_pkg;
  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_LO   = 2'b01,
    FMT_HI   = 2'b10,
    FMT_LH   = 2'b11
  } fmt_e;

  function automatic int pow10(input int n);
    int r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction
endpackage

// File: rtl/tmr_load_asm.sv
module tmr_load_asm
  import tmr_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  fmt_e              fmt,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  preset,
  output logic              load_go,
  output logic              loading
);
  logic              ptr_q, ptr_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              lo_en;
  logic [CNT_W-1:0]  preset_q, preset_d;
  logic              preset_en;
  logic              go_q, go_d;

  always_comb begin
    ptr_d     = ptr_q;
    lo_d      = wr_data;
    lo_en     = 1'b0;
    preset_d  = preset_q;
    preset_en = 1'b0;
    go_d      = 1'b0;
    if (clr) begin
      ptr_d = 1'b0;
    end else if (wr_stb) begin
      unique case (fmt)
        FMT_LO: begin
          preset_d  = {{BYTE_W{1'b0}}, wr_data};
          preset_en = 1'b1;
          go_d      = 1'b1;
        end
        FMT_HI: begin
          preset_d  = {wr_data, {BYTE_W{1'b0}}};
          preset_en = 1'b1;
          go_d      = 1'b1;
        end
        FMT_LH: begin
          if (!ptr_q) begin
            lo_en = 1'b1;
            ptr_d = 1'b1;
          end else begin
            preset_d  = {wr_data, lo_q};
            preset_en = 1'b1;
            ptr_d     = 1'b0;
            go_d      = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= 1'b0;
      lo_q     <= '0;
      preset_q <= '0;
      go_q     <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      go_q  <= go_d;
      if (lo_en)     lo_q     <= lo_d;
      if (preset_en) preset_q <= preset_d;
    end
  end

  assign preset  = preset_q;
  assign load_go = go_q;
  assign loading = ptr_q;
endmodule

// File: rtl/tmr_read_ser.sv
module tmr_read_ser
  import tmr_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  fmt_e              fmt,
  input  logic              rd_stb,
  input  logic              latch_stb,
  input  logic [CNT_W-1:0]  live,
  output logic [BYTE_W-1:0] rd_data
);
  logic             ptr_q, ptr_d;
  logic             held_q, held_d;
  logic [CNT_W-1:0] hold_q;
  logic             hold_en;
  logic [CNT_W-1:0] src;
  logic             seq_done;

  assign src = held_q ? hold_q : live;

  always_comb begin
    unique case (fmt)
      FMT_HI:  rd_data = src[CNT_W-1:BYTE_W];
      FMT_LH:  rd_data = ptr_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
      default: rd_data = src[BYTE_W-1:0];
    endcase
  end

  always_comb begin
    ptr_d    = ptr_q;
    held_d   = held_q;
    hold_en  = 1'b0;
    seq_done = 1'b0;
    if (clr) begin
      ptr_d  = 1'b0;
      held_d = 1'b0;
    end else begin
      if (rd_stb) begin
        if (fmt == FMT_LH && !ptr_q) begin
          ptr_d = 1'b1;
        end else begin
          ptr_d    = 1'b0;
          seq_done = 1'b1;
        end
      end
      if (seq_done) held_d = 1'b0;
      if (latch_stb && !held_q) begin
        held_d  = 1'b1;
        hold_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= 1'b0;
      held_q <= 1'b0;
      hold_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      held_q <= held_d;
      if (hold_en) hold_q <= live;
    end
  end
endmodule

// File: rtl/tmr_span_calc.sv
module tmr_span_calc
  import tmr_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int SPAN_W = CNT_W + 1,
  localparam int NDIG = CNT_W / 4
) (
  input  logic [CNT_W-1:0]  raw,
  input  logic              bcd,
  output logic [SPAN_W-1:0] span
);
  localparam logic [SPAN_W-1:0] BIN_FULL = SPAN_W'(1) << CNT_W;
  localparam logic [SPAN_W-1:0] BCD_FULL = SPAN_W'(pow10(NDIG));

  logic [SPAN_W-1:0] dec;

  always_comb begin
    dec = '0;
    for (int i = NDIG - 1; i >= 0; i--) begin
      dec = dec * SPAN_W'(10) + SPAN_W'(raw[4*i +: 4]);
    end
  end

  always_comb begin
    if (raw == '0) span = bcd ? BCD_FULL : BIN_FULL;
    else           span = bcd ? dec : SPAN_W'(raw);
  end
endmodule

// File: rtl/tmr_count_seq.sv
module tmr_count_seq
  import tmr_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W,
  localparam int SPAN_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_set,
  input  logic [1:0]        mode_fmt,
  input  logic              bcd_mode,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic              latch_stb,
  input  logic [CNT_W-1:0]  count_val,
  output logic [CNT_W-1:0]  preset,
  output logic [SPAN_W-1:0] preset_span,
  output logic              load_go,
  output logic              loading,
  output logic [BYTE_W-1:0] rd_data
);
  fmt_e fmt_q, fmt_d;
  logic mode_ok;

  assign mode_ok = mode_set && (fmt_e'(mode_fmt) != FMT_NONE);

  always_comb begin
    fmt_d = fmt_q;
    if (mode_ok) fmt_d = fmt_e'(mode_fmt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fmt_q <= FMT_LH;
    else        fmt_q <= fmt_d;
  end

  tmr_load_asm #(.BYTE_W(BYTE_W)) u_load (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (mode_ok),
    .fmt     (fmt_q),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .preset  (preset),
    .load_go (load_go),
    .loading (loading)
  );

  tmr_read_ser #(.BYTE_W(BYTE_W)) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mode_ok),
    .fmt       (fmt_q),
    .rd_stb    (rd_stb),
    .latch_stb (latch_stb),
    .live      (count_val),
    .rd_data   (rd_data)
  );

  tmr_span_calc #(.CNT_W(CNT_W)) u_span (
    .raw  (preset),
    .bcd  (bcd_mode),
    .span (preset_span)
  );
endmodule

// File: rtl/tmr_count_seq_chk.sv
module tmr_count_seq_chk #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W,
  localparam int SPAN_W = CNT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_set,
  input logic [1:0]        mode_fmt,
  input logic              bcd_mode,
  input logic              wr_stb,
  input logic [CNT_W-1:0]  preset,
  input logic [SPAN_W-1:0] preset_span,
  input logic              load_go,
  input logic              loading
);
  AST_GO_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |-> $past(wr_stb)); // R5

  AST_PRESET_ONLY_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
    !load_go |-> $stable(preset)); // R4

  AST_LOADING_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loading) |-> (load_go || $past(mode_set))); // R4

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_set && mode_fmt != 2'b00) |=> (!loading && !load_go)); // R10

  AST_SPAN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    preset_span != '0); // R12

  AST_SPAN_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bcd_mode && preset != '0) |-> (preset_span == SPAN_W'(preset))); // R12
endmodule

bind tmr_count_seq tmr_count_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_set    (mode_set),
  .mode_fmt    (mode_fmt),
  .bcd_mode    (bcd_mode),
  .wr_stb      (wr_stb),
  .preset      (preset),
  .preset_span (preset_span),
  .load_go     (load_go),
  .loading     (loading)
);

// File: tb/tmr_count_seq_tb.sv
module tmr_count_seq_tb;
  localparam int OP_NOP = 0, OP_MODE = 1, OP_WR = 2, OP_RD = 3, OP_LAT = 4;
  localparam int K_NONE = 0, K_PRE = 1, K_LDG = 2, K_RD = 3, K_SPAN = 4, K_IDLE = 5;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  fmt;
    logic        bcd;
    logic [7:0]  data;
    logic [15:0] cnt;
    logic [2:0]  kind;
    logic [16:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t TBL [NV] = '{
    '{3'(OP_MODE), 2'b01, 1'b0, 8'h00, 16'h0000, 3'(K_NONE), 17'h0,     4'd2},
    '{3'(OP_WR),   2'b00, 1'b0, 8'h34, 16'h0000, 3'(K_PRE),  17'h0034,  4'd2},  // R2
    '{3'(OP_MODE), 2'b10, 1'b0, 8'h00, 16'h0000, 3'(K_NONE), 17'h0,     4'd3},
    '{3'(OP_WR),   2'b00, 1'b0, 8'h56, 16'h0000, 3'(K_PRE),  17'h5600,  4'd3},  // R3
    '{3'(OP_MODE), 2'b11, 1'b0, 8'h00, 16'h0000, 3'(K_NONE), 17'h0,     4'd4},
    '{3'(OP_WR),   2'b00, 1'b0, 8'h78, 16'h0000, 3'(K_LDG),  17'h1,     4'd4},  // R4
    '{3'(OP_WR),   2'b00, 1'b0, 8'h9A, 16'h0000, 3'(K_PRE),  17'h9A78,  4'd4},  // R4
    '{3'(OP_NOP),  2'b00, 1'b0, 8'h00, 16'h0000, 3'(K_SPAN), 17'h09A78, 4'd12}, // R12
    '{3'(OP_MODE), 2'b11, 1'b0, 8'h00, 16'h0000, 3'(K_NONE), 17'h0,     4'd4},
    '{3'(OP_WR),   2'b00, 1'b0, 8'h00, 16'h0000, 3'(K_LDG),  17'h1,     4'd4},
    '{3'(OP_WR),   2'b00, 1'b0, 8'h00, 16'h0000, 3'(K_PRE),  17'h0000,  4'd4},
    '{3'(OP_NOP),  2'b00, 1'b0, 8'h00, 16'h0000, 3'(K_SPAN), 17'h10000, 4'd12}, // R12
    '{3'(OP_NOP),  2'b00, 1'b1, 8'h00, 16'h0000, 3'(K_SPAN), 17'd10000, 4'd12}, // R12
    '{3'(OP_WR),   2'b00, 1'b1, 8'h34, 16'h0000, 3'(K_LDG),  17'h1,     4'd4},
    '{3'(OP_WR),   2'b00, 1'b1, 8'h12, 16'h0000, 3'(K_PRE),  17'h1234,  4'd4},
    '{3'(OP_NOP),  2'b00, 1'b1, 8'h00, 16'h0000, 3'(K_SPAN), 17'd1234,  4'd12}, // R12
    '{3'(OP_MODE), 2'b01, 1'b0, 8'h00, 16'hBEEF, 3'(K_NONE), 17'h0,     4'd6},
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'hBEEF, 3'(K_RD),   17'hEF,    4'd6},  // R6
    '{3'(OP_MODE), 2'b10, 1'b0, 8'h00, 16'hBEEF, 3'(K_NONE), 17'h0,     4'd6},
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'hBEEF, 3'(K_RD),   17'hBE,    4'd6},  // R6
    '{3'(OP_MODE), 2'b11, 1'b0, 8'h00, 16'h1357, 3'(K_NONE), 17'h0,     4'd7},
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'h1357, 3'(K_RD),   17'h57,    4'd7},  // R7
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'h1357, 3'(K_RD),   17'h13,    4'd7},  // R7
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'h2468, 3'(K_RD),   17'h68,    4'd7},  // R7
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'h2468, 3'(K_RD),   17'h24,    4'd7},
    '{3'(OP_LAT),  2'b00, 1'b0, 8'h00, 16'hA1B2, 3'(K_NONE), 17'h0,     4'd8},
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'h0000, 3'(K_RD),   17'hB2,    4'd8},  // R8
    '{3'(OP_LAT),  2'b00, 1'b0, 8'h00, 16'h5555, 3'(K_NONE), 17'h0,     4'd9},
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'h1111, 3'(K_RD),   17'hA1,    4'd9},  // R9
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'h2211, 3'(K_RD),   17'h11,    4'd8},  // R8
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'h2211, 3'(K_RD),   17'h22,    4'd8},
    '{3'(OP_LAT),  2'b00, 1'b0, 8'h00, 16'h0F0E, 3'(K_NONE), 17'h0,     4'd10},
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'h0000, 3'(K_RD),   17'h0E,    4'd10},
    '{3'(OP_MODE), 2'b11, 1'b0, 8'h00, 16'h4433, 3'(K_NONE), 17'h0,     4'd10},
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'h4433, 3'(K_RD),   17'h33,    4'd10}, // R10
    '{3'(OP_RD),   2'b00, 1'b0, 8'h00, 16'h4433, 3'(K_RD),   17'h44,    4'd10},
    '{3'(OP_WR),   2'b00, 1'b0, 8'hAA, 16'h0000, 3'(K_LDG),  17'h1,     4'd10},
    '{3'(OP_MODE), 2'b11, 1'b0, 8'h00, 16'h0000, 3'(K_LDG),  17'h0,     4'd10}, // R10
    '{3'(OP_WR),   2'b00, 1'b0, 8'hBB, 16'h0000, 3'(K_LDG),  17'h1,     4'd10},
    '{3'(OP_WR),   2'b00, 1'b0, 8'hCC, 16'h0000, 3'(K_PRE),  17'hCCBB,  4'd10},
    '{3'(OP_MODE), 2'b00, 1'b0, 8'h00, 16'h0000, 3'(K_NONE), 17'h0,     4'd11},
    '{3'(OP_WR),   2'b00, 1'b0, 8'h11, 16'h0000, 3'(K_LDG),  17'h1,     4'd11}, // R11
    '{3'(OP_WR),   2'b00, 1'b0, 8'h22, 16'h0000, 3'(K_PRE),  17'h2211,  4'd11},
    '{3'(OP_NOP),  2'b00, 1'b0, 8'h00, 16'h0000, 3'(K_IDLE), 17'h0,     4'd5}   // R5
  };

  logic        clk, rst_n;
  logic        mode_set, bcd_mode, wr_stb, rd_stb, latch_stb;
  logic [1:0]  mode_fmt;
  logic [7:0]  wr_data, rd_data;
  logic [15:0] count_val, preset;
  logic [16:0] preset_span;
  logic        load_go, loading;
  int          n_chk, n_err;

  tmr_count_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_fmt(mode_fmt),
    .bcd_mode(bcd_mode), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .latch_stb(latch_stb), .count_val(count_val), .preset(preset),
    .preset_span(preset_span), .load_go(load_go), .loading(loading),
    .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input int req, input logic [16:0] got, input logic [16:0] exp,
                       input string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  task automatic idle_inputs();
    mode_set = 0; wr_stb = 0; rd_stb = 0; latch_stb = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    n_chk = 0; n_err = 0;
    idle_inputs();
    mode_fmt = 2'b00; bcd_mode = 0; wr_data = 0; count_val = 16'h1234;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(1, 17'(preset), 17'h0, "preset after reset");
    check(1, 17'(load_go), 17'h0, "load_go after reset");
    check(1, 17'(loading), 17'h0, "loading after reset");
    check(1, 17'(rd_data), 17'h34, "rd_data low byte after reset");
    rst_n = 1;
    @(negedge clk);
    wr_stb = 1; wr_data = 8'h21;
    @(posedge clk); #2; idle_inputs();
    check(1, 17'(loading), 17'h1, "default format is two-byte");

    // Reset mid-load clears loading (R1)
    @(negedge clk); rst_n = 0;
    #2 check(1, 17'(loading), 17'h0, "async reset clears loading");
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      count_val = TBL[i].cnt;
      bcd_mode  = TBL[i].bcd;
      mode_fmt  = TBL[i].fmt;
      wr_data   = TBL[i].data;
      case (int'(TBL[i].op))
        OP_MODE: mode_set  = 1;
        OP_WR:   wr_stb    = 1;
        OP_RD:   rd_stb    = 1;
        OP_LAT:  latch_stb = 1;
        default: ;
      endcase
      #1;
      if (int'(TBL[i].kind) == K_RD)
        check(int'(TBL[i].req), 17'(rd_data), TBL[i].exp, $sformatf("read byte step %0d", i));
      @(posedge clk); #2;
      idle_inputs();
      case (int'(TBL[i].kind))
        K_PRE: begin
          check(int'(TBL[i].req), 17'(preset), TBL[i].exp, $sformatf("preset step %0d", i));
          check(int'(TBL[i].req), 17'(load_go), 17'h1, $sformatf("load_go step %0d", i));
          check(int'(TBL[i].req), 17'(loading), 17'h0, $sformatf("loading step %0d", i));
        end
        K_LDG: begin
          check(int'(TBL[i].req), 17'(loading), TBL[i].exp, $sformatf("loading step %0d", i));
          check(int'(TBL[i].req), 17'(load_go), 17'h0, $sformatf("no load_go step %0d", i));
        end
        K_SPAN: check(int'(TBL[i].req), preset_span, TBL[i].exp, $sformatf("span step %0d", i));
        K_IDLE: check(int'(TBL[i].req), 17'(load_go), 17'h0, $sformatf("load_go idle step %0d", i));
        default: ;
      endcase
    end

    // R5: back-to-back single-byte writes give one pulse each, then drop
    @(negedge clk); mode_set = 1; mode_fmt = 2'b01;
    @(posedge clk); #2; idle_inputs();
    @(negedge clk); wr_stb = 1; wr_data = 8'h05;
    @(posedge clk); #2;
    check(5, 17'(load_go), 17'h1, "first pulse");
    wr_data = 8'h06;
    @(posedge clk); #2; idle_inputs();
    check(5, 17'(preset), 17'h0006, "second load");
    @(posedge clk); #2;
    check(5, 17'(load_go), 17'h0, "pulse ends");

    // R4: preset held between the two bytes of a load
    @(negedge clk); mode_set = 1; mode_fmt = 2'b11;
    @(posedge clk); #2; idle_inputs();
    @(negedge clk); wr_stb = 1; wr_data = 8'hEE;
    @(posedge clk); #2; idle_inputs();
    check(4, 17'(preset), 17'h0006, "preset unchanged after first byte");
    summary();
  end
endmodule